// File: doc/BRIEF.md
# SPI Command Decoder for a Dual Receiver

This block is the serial front end of a two-channel word receiver. An SPI master (clock idle low, data captured on the rising clock edge, most significant bit first) frames each command with chip select. The first byte of a frame is a command code. That one byte selects both the receiver channel and the kind of transfer. A fixed payload follows: four bytes when a received word is read out, and thirty-two bytes when a 256-bit label table is loaded or read back.

The receive FIFOs and the label tables live outside this block. Each FIFO presents its head word and accepts a one-cycle pop strobe. Each table takes byte writes and answers byte reads through a shared byte address. Command codes that this block does not handle run as silent frames.

The SPI pins are brought into the system clock domain by synchronizers. The system clock must run at least four times faster than the serial clock.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset, and whenever chip select is high, miso_o is 0 and no pop or table-write strobe is raised.
- R2: Command 0xA0 pulses fifo_pop_o[0] and command 0xC0 pulses fifo_pop_o[1]. The pulse lasts exactly one clock, occurs once per frame, and comes in the cycle the eighth command bit is taken.
- R3: After a pop command, the next four bytes on miso_o carry the FIFO head word that was present when the pop strobe fired, most significant byte first and each byte most significant bit first.
- R4: Command 0x14 loads table 0 and command 0x28 loads table 1 (tbl_we_o bit 0 is table 0). Each of the 32 payload bytes is written as it completes. The byte address starts at 31 and falls to 0. Byte address A, bit k holds label 8*A+k, so the first byte carries labels 255 down to 248.
- R5: Command 0x98 reads table 0 and command 0xB8 reads table 1. The 32 payload bytes on miso_o are table bytes 31 down to 0, in that order, taken from tbl_rdata_i of the selected table at the address on tbl_addr_o.
- R6: Bytes clocked after a command's payload is complete return 0 on miso_o and cause no pop or write.
- R7: Any other command code returns 0 on miso_o for the whole frame and raises no pop or write.
- R8: Raising chip select ends a frame at any bit. A partly shifted byte is dropped without any write or pop. The next frame begins again with a command byte.
- R9: miso_o is 0 throughout the command byte.
- R10: With the system clock at four times the serial clock, each miso_o bit is stable before the serial clock edge on which the master captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| fifo_pop_o | output | 2 | Pop strobe for each receive FIFO |
| fifo_word_i | input | 2x32 | Head word of each receive FIFO |
| tbl_we_o | output | 2 | Byte write enable for each label table |
| tbl_addr_o | output | 5 | Byte address shared by table writes and reads |
| tbl_wdata_o | output | 8 | Table write byte |
| tbl_rdata_i | input | 2x8 | Byte of each table at tbl_addr_o |

## Verification
A pop or table write fires in the system cycle in which the synchronized serial clock shows the rising edge of a byte's eighth bit. That is about two to three system clocks after the pin edge. The next miso_o bit is registered one clock after that edge. The bench changes pins on falling system-clock edges. It samples miso_o on a falling system-clock edge just before it raises the serial clock, the latest point at which the master still needs the bit. Strobes are counted by a monitor on every rising system-clock edge. The counts and the table contents are compared only after chip select has been high for eight clocks, so all synchronizer stages have drained. The R10 case repeats a FIFO read with a half serial period of two system clocks.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] CMD_POP_A  = 8'hA0;
  localparam logic [7:0] CMD_POP_B  = 8'hC0;
  localparam logic [7:0] CMD_TWR_A  = 8'h14;
  localparam logic [7:0] CMD_TWR_B  = 8'h28;
  localparam logic [7:0] CMD_TRD_A  = 8'h98;
  localparam logic [7:0] CMD_TRD_B  = 8'hB8;

  typedef enum logic [1:0] {
    K_NONE,
    K_POP,
    K_TWR,
    K_TRD
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e kind;
    logic      ch;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [7:0] code);
    cmd_dec_t d;
    d.kind = K_NONE;
    d.ch   = 1'b0;
    case (code)
      CMD_POP_A: d.kind = K_POP;
      CMD_POP_B: begin d.kind = K_POP; d.ch = 1'b1; end
      CMD_TWR_A: d.kind = K_TWR;
      CMD_TWR_B: begin d.kind = K_TWR; d.ch = 1'b1; end
      CMD_TRD_A: d.kind = K_TRD;
      CMD_TRD_B: begin d.kind = K_TRD; d.ch = 1'b1; end
      default:   d.kind = K_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic frame_act_o,
  output logic mosi_o
);

  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sclk_prev;

  // index 0: sclk, 1: chip select (active high), 2: mosi
  assign raw = {mosi_i, ~cs_ni, sclk_i};

  for (genvar k = 0; k < NSIG; k++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], raw[k]};
    end
    assign synced[k] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev <= 1'b0;
    else         sclk_prev <= synced[0];
  end

  assign sclk_rise_o = synced[0] & ~sclk_prev;
  assign frame_act_o = synced[1];
  assign mosi_o      = synced[2];

  p_rise_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise_o |=> !sclk_rise_o);

endmodule

// File: rtl/spi_cmd_bitio.sv
module spi_cmd_bitio #(
  parameter int TX_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_act_i,
  input  logic            rise_i,
  input  logic            mosi_i,
  input  logic            load_i,
  input  logic [TX_W-1:0] load_data_i,
  output logic            byte_done_o,
  output logic [7:0]      rx_byte_o,
  output logic            miso_o
);

  logic [2:0]      bit_cnt;
  logic [6:0]      rx_sr;
  logic [TX_W-1:0] tx_sr;
  logic            step;

  assign step        = frame_act_i & rise_i;
  assign byte_done_o = step && (bit_cnt == 3'd7);
  assign rx_byte_o   = {rx_sr, mosi_i};
  assign miso_o      = tx_sr[TX_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
    end else if (!frame_act_i) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
    end else begin
      if (step) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sr   <= {rx_sr[5:0], mosi_i};
      end
      // the master has just captured the current bit: present the next one
      if (load_i)    tx_sr <= load_data_i;
      else if (step) tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
    end
  end

  p_load_at_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> byte_done_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_act_i |=> !miso_o);

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int TBL_BYTES = 32,
  localparam int ADDR_W   = $clog2(TBL_BYTES),
  localparam int CNT_W    = $clog2(TBL_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_act_i,
  input  logic                   byte_done_i,
  input  logic [7:0]             rx_byte_i,
  input  logic [1:0][WORD_W-1:0] fifo_word_i,
  input  logic [1:0][7:0]        tbl_rdata_i,
  output logic                   load_o,
  output logic [WORD_W-1:0]      load_data_o,
  output logic [1:0]             fifo_pop_o,
  output logic [1:0]             tbl_we_o,
  output logic [ADDR_W-1:0]      tbl_addr_o,
  output logic [7:0]             tbl_wdata_o
);

  typedef enum logic [1:0] {
    PH_CMD,
    PH_TWR,
    PH_TRD,
    PH_SKIP
  } phase_e;

  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(TBL_BYTES - 1);

  phase_e            state_q;
  logic              ch_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  cmd_dec_t          dec;

  assign dec         = decode_cmd(rx_byte_i);
  assign tbl_addr_o  = addr_q;
  assign tbl_wdata_o = rx_byte_i;

  always_comb begin
    load_o      = 1'b0;
    load_data_o = '0;
    fifo_pop_o  = '0;
    tbl_we_o    = '0;
    if (byte_done_i) begin
      case (state_q)
        PH_CMD: begin
          if (dec.kind == K_POP) begin
            fifo_pop_o[dec.ch] = 1'b1;
            load_o             = 1'b1;
            load_data_o        = fifo_word_i[dec.ch];
          end else if (dec.kind == K_TRD) begin
            load_o      = 1'b1;
            load_data_o = {tbl_rdata_i[dec.ch], {(WORD_W-8){1'b0}}};
          end
        end
        PH_TWR: tbl_we_o[ch_q] = 1'b1;
        PH_TRD: begin
          if (cnt_q < LAST_BYTE) begin
            load_o      = 1'b1;
            load_data_o = {tbl_rdata_i[ch_q], {(WORD_W-8){1'b0}}};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_CMD;
      ch_q    <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '1;
    end else if (!frame_act_i) begin
      state_q <= PH_CMD;
      ch_q    <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '1;
    end else if (byte_done_i) begin
      case (state_q)
        PH_CMD: begin
          ch_q  <= dec.ch;
          cnt_q <= '0;
          case (dec.kind)
            K_TWR:   state_q <= PH_TWR;
            K_TRD: begin
              state_q <= PH_TRD;
              addr_q  <= addr_q - 1'b1;  // keep pointing at the next byte to send
            end
            default: state_q <= PH_SKIP;
          endcase
        end
        PH_TWR, PH_TRD: begin
          cnt_q  <= cnt_q + 1'b1;
          addr_q <= addr_q - 1'b1;
          if (cnt_q == LAST_BYTE) state_q <= PH_SKIP;
        end
        default: ;
      endcase
    end
  end

  p_pop_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fifo_pop_o));

  p_pop_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_pop_o != 2'b00) |=> (state_q == PH_SKIP));

  p_we_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we_o != 2'b00) |=> (addr_q == $past(addr_q) - 1'b1));

  p_skip_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_SKIP) |-> (fifo_pop_o == 2'b00 && tbl_we_o == 2'b00 && !load_o));

  p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((fifo_pop_o != 2'b00) && (tbl_we_o != 2'b00)));

  p_strobe_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fifo_pop_o != 2'b00) || (tbl_we_o != 2'b00)) |-> frame_act_i);

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder #(
  parameter int WORD_W      = 32,
  parameter int TBL_BITS    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               sclk_i,
  input  logic                               cs_ni,
  input  logic                               mosi_i,
  output logic                               miso_o,
  output logic [1:0]                         fifo_pop_o,
  input  logic [1:0][WORD_W-1:0]             fifo_word_i,
  output logic [1:0]                         tbl_we_o,
  output logic [$clog2(TBL_BITS/8)-1:0]      tbl_addr_o,
  output logic [7:0]                         tbl_wdata_o,
  input  logic [1:0][7:0]                    tbl_rdata_i
);

  localparam int TBL_BYTES = TBL_BITS / 8;

  logic              sclk_rise;
  logic              frame_act;
  logic              mosi_s;
  logic              byte_done;
  logic [7:0]        rx_byte;
  logic              load;
  logic [WORD_W-1:0] load_data;

  spi_cmd_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .cs_ni      (cs_ni),
    .mosi_i     (mosi_i),
    .sclk_rise_o(sclk_rise),
    .frame_act_o(frame_act),
    .mosi_o     (mosi_s)
  );

  spi_cmd_bitio #(
    .TX_W(WORD_W)
  ) u_bitio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_act_i(frame_act),
    .rise_i     (sclk_rise),
    .mosi_i     (mosi_s),
    .load_i     (load),
    .load_data_i(load_data),
    .byte_done_o(byte_done),
    .rx_byte_o  (rx_byte),
    .miso_o     (miso_o)
  );

  spi_cmd_ctrl #(
    .WORD_W   (WORD_W),
    .TBL_BYTES(TBL_BYTES)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_act_i(frame_act),
    .byte_done_i(byte_done),
    .rx_byte_i  (rx_byte),
    .fifo_word_i(fifo_word_i),
    .tbl_rdata_i(tbl_rdata_i),
    .load_o     (load),
    .load_data_o(load_data),
    .fifo_pop_o (fifo_pop_o),
    .tbl_we_o   (tbl_we_o),
    .tbl_addr_o (tbl_addr_o),
    .tbl_wdata_o(tbl_wdata_o)
  );

  p_cmd_byte_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_act) |=> (!miso_o));

endmodule

// File: tb/spi_cmd_decoder_test.sv
`timescale 1ns/1ps
module spi_cmd_decoder_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  logic [1:0] pop;
  logic [1:0][31:0] fword;
  logic [1:0] we;
  logic [4:0] taddr;
  logic [7:0] twdata;
  logic [1:0][7:0] trdata;

  always #2.5 clk = ~clk;

  spi_cmd_decoder uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sclk_i     (sclk),
    .cs_ni      (cs_n),
    .mosi_i     (mosi),
    .miso_o     (miso),
    .fifo_pop_o (pop),
    .fifo_word_i(fword),
    .tbl_we_o   (we),
    .tbl_addr_o (taddr),
    .tbl_wdata_o(twdata),
    .tbl_rdata_i(trdata)
  );

  // external FIFO and table models
  logic [31:0] fq0 [4];
  logic [31:0] fq1 [4];
  int p0 = 0, p1 = 0;
  logic [7:0] tb0 [32];
  logic [7:0] tb1 [32];
  int pops0 = 0, pops1 = 0, wr0 = 0, wr1 = 0;

  assign fword  = {fq1[p1 % 4], fq0[p0 % 4]};
  assign trdata = {tb1[taddr], tb0[taddr]};

  always @(posedge clk) begin
    if (pop[0]) begin p0 <= p0 + 1; pops0 <= pops0 + 1; end
    if (pop[1]) begin p1 <= p1 + 1; pops1 <= pops1 + 1; end
    if (we[0]) begin tb0[taddr] <= twdata; wr0 <= wr0 + 1; end
    if (we[1]) begin tb1[taddr] <= twdata; wr1 <= wr1 + 1; end
  end

  int n_cmp = 0, n_err = 0;
  int half = 4;
  bit finished = 1'b0;
  logic [7:0] txb [40];
  logic [7:0] rxb [40];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int sel, input int i);
    return 8'((i * 37 + 11 + sel * 101) ^ (sel * 8'h5A));
  endfunction

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    repeat (half) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (half) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] b, input int nbits, output logic [7:0] r);
    r = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = b[i];
      repeat (half) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (half) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic run_frame(input int n);
    logic [7:0] r;
    cs_low();
    for (int k = 0; k < n; k++) begin
      xfer_bits(txb[k], 8, r);
      rxb[k] = r;
    end
    cs_high();
  endtask

  task automatic t_reset();
    chk("R1", "miso after reset", 32'(miso), 32'h0);
    chk("R1", "pop after reset", 32'(pop), 32'h0);
    chk("R1", "we after reset", 32'(we), 32'h0);
  endtask

  task automatic t_fifo(input logic [7:0] op, input int ch, input logic [31:0] exp_word, input int extra, input string req);
    int b0 = pops0, b1 = pops1;
    txb[0] = op;
    for (int k = 1; k < 5 + extra; k++) txb[k] = 8'hFF;
    run_frame(5 + extra);
    chk("R9", "cmd byte miso", 32'(rxb[0]), 32'h0);
    chk(req, "word out", {rxb[1], rxb[2], rxb[3], rxb[4]}, exp_word);
    chk("R2", "pops ch0", 32'(pops0 - b0), (ch == 0) ? 32'd1 : 32'd0);
    chk("R2", "pops ch1", 32'(pops1 - b1), (ch == 1) ? 32'd1 : 32'd0);
    for (int k = 5; k < 5 + extra; k++) chk("R6", "trailing byte", 32'(rxb[k]), 32'h0);
    chk("R1", "miso idle", 32'(miso), 32'h0);
  endtask

  task automatic t_tbl_write(input logic [7:0] op, input int ch);
    int w0 = wr0, w1 = wr1;
    txb[0] = op;
    for (int i = 0; i < 32; i++) txb[i + 1] = pat(ch, i);
    txb[33] = 8'h3C;
    run_frame(34);
    chk("R4", "writes ch0", 32'(wr0 - w0), (ch == 0) ? 32'd32 : 32'd0);
    chk("R4", "writes ch1", 32'(wr1 - w1), (ch == 1) ? 32'd32 : 32'd0);
    for (int i = 0; i < 32; i++)
      chk("R4", "table byte", 32'((ch == 0) ? tb0[31 - i] : tb1[31 - i]), 32'(pat(ch, i)));
  endtask

  task automatic t_tbl_read(input logic [7:0] op, input int ch);
    int w0 = wr0, w1 = wr1;
    txb[0] = op;
    for (int i = 1; i < 34; i++) txb[i] = 8'hA5;
    run_frame(34);
    chk("R9", "cmd byte miso", 32'(rxb[0]), 32'h0);
    for (int i = 0; i < 32; i++)
      chk("R5", "readback byte", 32'(rxb[i + 1]), 32'((ch == 0) ? tb0[31 - i] : tb1[31 - i]));
    chk("R6", "byte after table", 32'(rxb[33]), 32'h0);
    chk("R5", "no writes on read", 32'((wr0 - w0) + (wr1 - w1)), 32'd0);
  endtask

  task automatic t_unknown(input logic [7:0] op);
    int b = pops0 + pops1 + wr0 + wr1;
    txb[0] = op;
    for (int i = 1; i < 5; i++) txb[i] = 8'h96;
    run_frame(5);
    for (int i = 0; i < 5; i++) chk("R7", "unknown cmd miso", 32'(rxb[i]), 32'h0);
    chk("R7", "unknown cmd strobes", 32'(pops0 + pops1 + wr0 + wr1 - b), 32'd0);
  endtask

  task automatic t_abort_cmd();
    logic [7:0] r;
    int b = pops0 + pops1;
    cs_low();
    xfer_bits(8'hA0, 5, r);
    cs_high();
    chk("R8", "no pop on cut cmd", 32'(pops0 + pops1 - b), 32'd0);
  endtask

  task automatic t_abort_write();
    logic [7:0] r;
    int w = wr0;
    cs_low();
    xfer_bits(8'h14, 8, r);
    for (int i = 0; i < 3; i++) xfer_bits(pat(2, i), 8, r);
    xfer_bits(8'hFF, 4, r);
    cs_high();
    chk("R8", "writes before cut", 32'(wr0 - w), 32'd3);
    chk("R8", "partial byte dropped", 32'(tb0[28]), 32'(pat(0, 3)));
    // a fresh frame must start with a command byte
    txb[0] = 8'h98;
    for (int i = 1; i < 33; i++) txb[i] = 8'h00;
    run_frame(33);
    for (int i = 0; i < 32; i++)
      chk("R8", "table after cut", 32'(rxb[i + 1]), 32'((i < 3) ? pat(2, i) : pat(0, i)));
  endtask

  initial begin
    fq0[0] = 32'hA5C3_1E77; fq0[1] = 32'h0123_4567; fq0[2] = 32'h89AB_CDEF; fq0[3] = 32'h0;
    fq1[0] = 32'h5A3C_E188; fq1[1] = 32'hF00D_8001; fq1[2] = 32'h0;         fq1[3] = 32'h0;
    for (int i = 0; i < 32; i++) begin tb0[i] = 8'h00; tb1[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fifo(8'hA0, 0, 32'hA5C3_1E77, 0, "R3");
    t_fifo(8'hC0, 1, 32'h5A3C_E188, 0, "R3");
    t_fifo(8'hA0, 0, 32'h0123_4567, 2, "R3");
    t_tbl_write(8'h14, 0);
    t_tbl_write(8'h28, 1);
    t_tbl_read(8'h98, 0);
    t_tbl_read(8'hB8, 1);
    t_unknown(8'h55);
    t_unknown(8'hA1);
    t_unknown(8'h00);
    t_abort_cmd();
    t_fifo(8'hA0, 0, 32'h89AB_CDEF, 0, "R8");
    t_abort_write();
    half = 2;
    t_fifo(8'hC0, 1, 32'hF00D_8001, 1, "R10");
    half = 4;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

endmodule